// File: doc/BRIEF.md
# Response Ring Writer

This block is the controller-side engine that stores 64-bit codec responses into a circular response ring held in system memory. Each accepted response is written to the slot after the current hardware write index, and the index is published only once the memory write has completed. Software polls that index and treats the ring as empty while its own read index equals it.

Software programs the engine through a small register window: a 128-byte-aligned ring base split into lower and upper words, the write index with a self-clearing reset command, a response count limit, a control byte, a status byte with write-one-to-clear flags, and a size byte that reports the supported depths and selects one. The engine counts stored responses against the programmed limit. It does this whether or not the interrupt is enabled. When the limit is reached it flags status, may raise the interrupt, and stops taking responses until software clears the flag. A response that would land on a slot software has not yet consumed is dropped and flagged. The software read index reaches the engine on a dedicated input.

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset the write index (offset 0x8), count limit (0xA), control (0xC) and status (0xD) all read 0. The size byte (0xE) reads 0x70: bits 6:4 give the capability mask 3'b111 and bits 1:0 give the select 00.
- R2: Each stored response goes to slot s = (write index + 1) mod depth. The write address is {upper base, lower base with bits 6:0 cleared} + 8*s, and the write carries the 64-bit response. The write index becomes s in the cycle after mem_ready completes the write.
- R3: Size select bits 1:0 choose the depth: 00 gives 2 entries, 01 gives 16 and 10 gives 256. A write of 11 leaves the select unchanged.
- R4: Writing offset 0x8 with bit 15 set clears the write index to 0 and restarts the response count. Writes to 0x8 with bit 15 clear leave the index unchanged.
- R5: Control bit 1 enables intake and reads back its new value at once. While it is 0, rsp_ready stays low and no new memory write starts.
- R6: When a stored response brings the count to the value at offset 0xA, status bit 0 is set and the count restarts. A limit of 0 means 256 responses. This happens even with control bit 0 clear. rsp_ready then stays low until software writes 1 to status bit 0.
- R7: irq is high exactly while status bit 0 and control bit 0 are both 1.
- R8: If the slot s equals host_rd_idx, the response is accepted, status bit 2 is set, no memory write is made and the write index is unchanged. Writing 1 to status bit 2 clears it.
- R9: mem_req stays high, with mem_addr and mem_data stable, until mem_ready is seen.
- R10: The lower base (offset 0x0) reads back with bits 6:0 as zero. The upper base (0x4) reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rsp_valid | input | 1 | Response offered |
| rsp_data | input | 64 | Response word |
| rsp_ready | output | 1 | Engine takes the response this cycle |
| host_rd_idx | input | 8 | Software read index |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory write byte address |
| mem_data | output | 64 | Memory write data |
| mem_ready | input | 1 | Memory write accepted |
| irq | output | 1 | Count-reached interrupt |

## Verification
The bench builds the block with its default parameters: a 64-bit entry, a capability mask of 3'b111 and a reset select of 00. With these values all three depths can be selected at run time. The 2- and 16-entry rings let the bench reach wrap-around and the full-ring drop within a few dozen responses, while the 256-entry ring checks the wider address offsets. A memory that withholds mem_ready on every third cycle exercises request holding and the timing of index publication, and a small count limit brings the stall and interrupt paths within reach.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;
    localparam int PTR_W = 8;

    localparam logic [3:0] OFS_LBASE = 4'h0;
    localparam logic [3:0] OFS_UBASE = 4'h4;
    localparam logic [3:0] OFS_WIDX  = 4'h8;
    localparam logic [3:0] OFS_LIMIT = 4'hA;
    localparam logic [3:0] OFS_CTL   = 4'hC;
    localparam logic [3:0] OFS_STS   = 4'hD;
    localparam logic [3:0] OFS_SIZE  = 4'hE;

    typedef enum logic {ENG_IDLE, ENG_STORE} eng_state_e;

    function automatic logic [PTR_W-1:0] depth_mask(input logic [1:0] sel);
        case (sel)
            2'b00:   return 8'h01;
            2'b01:   return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/rsp_ring_slot.sv
module rsp_ring_slot
    import rsp_ring_pkg::*;
(
    input  logic [PTR_W-1:0] widx,
    input  logic [1:0]       sel,
    input  logic [PTR_W-1:0] host_rd,
    output logic [PTR_W-1:0] slot,
    output logic             full
);
    assign slot = (widx + 1'b1) & depth_mask(sel);
    assign full = (slot == host_rd);
endmodule

// File: rtl/rsp_ring_addr.sv
module rsp_ring_addr #(
    parameter int AW    = 64,
    parameter int SW    = 8,
    parameter int ALIGN = 7
) (
    input  logic [31:0]         ubase,
    input  logic [31-ALIGN:0]   lbase,
    input  logic [SW-1:0]       slot,
    output logic [AW-1:0]       addr
);
    localparam int OFS_PAD = AW - SW - 3;
    assign addr = {ubase, lbase, {ALIGN{1'b0}}} + {{OFS_PAD{1'b0}}, slot, 3'b000};
endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer
    import rsp_ring_pkg::*;
#(
    parameter int         ENTRY_W      = 64,
    parameter logic [2:0] CAP_MASK     = 3'b111,
    parameter logic [1:0] SIZE_SEL_RST = 2'b00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               rsp_valid,
    input  logic [ENTRY_W-1:0] rsp_data,
    output logic               rsp_ready,
    input  logic [PTR_W-1:0]   host_rd_idx,
    output logic               mem_req,
    output logic [63:0]        mem_addr,
    output logic [ENTRY_W-1:0] mem_data,
    input  logic               mem_ready,
    output logic               irq
);
    localparam int ALIGN = 7;

    typedef struct packed {
        logic [31:0]        ubase;
        logic [31-ALIGN:0]  lbase;
        logic [PTR_W-1:0]   widx;
        logic [PTR_W-1:0]   limit;
        logic [PTR_W-1:0]   count;
        logic               ien;
        logic               run;
        logic               hit;
        logic               ovr;
        logic [1:0]         sel;
        eng_state_e         st;
        logic [PTR_W-1:0]   slot;
        logic [ENTRY_W-1:0] data;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [PTR_W-1:0] next_slot;
    logic             ring_full;
    logic             take, done, hit_set, ovr_set, idx_reset;

    rsp_ring_slot u_slot (
        .widx    (regs_q.widx),
        .sel     (regs_q.sel),
        .host_rd (host_rd_idx),
        .slot    (next_slot),
        .full    (ring_full)
    );

    rsp_ring_addr #(.AW(64), .SW(PTR_W), .ALIGN(ALIGN)) u_addr (
        .ubase (regs_q.ubase),
        .lbase (regs_q.lbase),
        .slot  (regs_q.slot),
        .addr  (mem_addr)
    );

    assign rsp_ready = regs_q.run && !regs_q.hit && (regs_q.st == ENG_IDLE);
    assign take      = rsp_valid && rsp_ready;
    assign done      = (regs_q.st == ENG_STORE) && mem_ready;
    assign mem_req   = (regs_q.st == ENG_STORE);
    assign mem_data  = regs_q.data;
    assign irq       = regs_q.hit && regs_q.ien;
    assign idx_reset = reg_wr && (reg_addr == OFS_WIDX) && reg_wdata[15];

    always_comb begin
        regs_d  = regs_q;
        hit_set = 1'b0;
        ovr_set = 1'b0;
        if (take) begin
            if (ring_full) begin
                ovr_set = 1'b1;
            end else begin
                regs_d.st   = ENG_STORE;
                regs_d.slot = next_slot;
                regs_d.data = rsp_data;
            end
        end
        if (done) begin
            regs_d.st   = ENG_IDLE;
            regs_d.widx = regs_q.slot;
            if (regs_q.count + 1'b1 == regs_q.limit) begin
                regs_d.count = '0;
                hit_set      = 1'b1;
            end else begin
                regs_d.count = regs_q.count + 1'b1;
            end
        end
        if (reg_wr) begin
            case (reg_addr)
                OFS_LBASE: regs_d.lbase = reg_wdata[31:ALIGN];
                OFS_UBASE: regs_d.ubase = reg_wdata;
                OFS_WIDX:  if (reg_wdata[15]) begin
                               regs_d.widx  = '0;
                               regs_d.count = '0;
                           end
                OFS_LIMIT: regs_d.limit = reg_wdata[PTR_W-1:0];
                OFS_CTL: begin
                    regs_d.ien = reg_wdata[0];
                    regs_d.run = reg_wdata[1];
                end
                OFS_STS: begin
                    if (reg_wdata[0]) regs_d.hit = 1'b0;
                    if (reg_wdata[2]) regs_d.ovr = 1'b0;
                end
                OFS_SIZE:  if (reg_wdata[1:0] != 2'b11) regs_d.sel = reg_wdata[1:0];
                default: ;
            endcase
        end
        if (hit_set) regs_d.hit = 1'b1;
        if (ovr_set) regs_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.sel <= SIZE_SEL_RST;
            regs_q.st  <= ENG_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_LBASE: reg_rdata = {regs_q.lbase, {ALIGN{1'b0}}};
            OFS_UBASE: reg_rdata = regs_q.ubase;
            OFS_WIDX:  reg_rdata[PTR_W-1:0] = regs_q.widx;
            OFS_LIMIT: reg_rdata[PTR_W-1:0] = regs_q.limit;
            OFS_CTL:   reg_rdata[1:0] = {regs_q.run, regs_q.ien};
            OFS_STS:   reg_rdata[2:0] = {regs_q.ovr, 1'b0, regs_q.hit};
            OFS_SIZE:  reg_rdata[7:0] = {1'b0, CAP_MASK, 2'b00, regs_q.sel};
            default:   reg_rdata = '0;
        endcase
    end

    // R9: an outstanding write keeps its request, address and data
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_data));

    // R2: the index moves to the stored slot once the write completes
    a_r2_publish: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && !idx_reset |=> regs_q.widx == $past(regs_q.slot));

    // R6: the count flag persists until software clears it
    a_r6_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.hit && !(reg_wr && reg_addr == OFS_STS && reg_wdata[0]) |=> regs_q.hit);

    // R8: a response taken into a full ring makes no memory write
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && ring_full |=> !mem_req);

    // R5: no write starts while intake is disabled
    a_r5_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.run && !mem_req |=> !mem_req);
endmodule

// File: tb/rsp_ring_writer_test.sv
module rsp_ring_writer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        rsp_ready;
    logic [7:0]  host_rd_idx = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic [63:0] mem_data;
    logic        mem_ready = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    rsp_ring_writer uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    int m_wp, m_lim, m_cnt, m_sel, m_slot;
    bit m_run, m_ien, m_hit, m_ovr, m_busy;
    longint unsigned m_ubase, m_lbase;
    longint unsigned exp_addr[$];
    longint unsigned exp_data[$];
    bit pend;
    logic [63:0] pend_addr, pend_data;

    function automatic int depth_of(int s);
        return (s == 0) ? 2 : (s == 1) ? 16 : 256;
    endfunction

    function automatic bit model_ready();
        return m_run && !m_hit && !m_busy;
    endfunction

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wp = 0; m_lim = 0; m_cnt = 0; m_sel = 0; m_slot = 0;
            m_run = 0; m_ien = 0; m_hit = 0; m_ovr = 0; m_busy = 0;
            m_ubase = 0; m_lbase = 0; pend = 0;
            exp_addr.delete(); exp_data.delete();
        end else begin
            bit hs, hv, ov, acc, dn;
            hs = 0; ov = 0;
            acc = rsp_valid && model_ready();
            dn  = m_busy && mem_ready;
            if (mem_req && mem_ready) begin
                if (exp_addr.size() == 0) check("R2 unexpected write", 1, 0);
                else begin
                    check("R2 write address", mem_addr, exp_addr.pop_front());
                    check("R2 write data", mem_data, exp_data.pop_front());
                end
            end
            if (pend) begin
                check("R9 held address", mem_addr, pend_addr);
                check("R9 held data", mem_data, pend_data);
            end
            pend = mem_req && !mem_ready;
            pend_addr = mem_addr; pend_data = mem_data;
            if (dn) begin
                m_busy = 0; m_wp = m_slot;
                if (((m_cnt + 1) % 256) == m_lim) begin m_cnt = 0; hs = 1; end
                else m_cnt = (m_cnt + 1) % 256;
            end
            if (acc) begin
                int ns;
                ns = (m_wp + 1) % depth_of(m_sel);
                if (ns == host_rd_idx) ov = 1;
                else begin
                    m_busy = 1; m_slot = ns;
                    exp_addr.push_back((m_ubase << 32) + m_lbase + ns * 8);
                    exp_data.push_back(rsp_data);
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    4'h0: m_lbase = reg_wdata & 32'hFFFF_FF80;
                    4'h4: m_ubase = reg_wdata;
                    4'h8: if (reg_wdata[15]) begin m_wp = 0; m_cnt = 0; end
                    4'hA: m_lim = reg_wdata[7:0];
                    4'hC: begin m_ien = reg_wdata[0]; m_run = reg_wdata[1]; end
                    4'hD: begin
                        if (reg_wdata[0]) m_hit = 0;
                        if (reg_wdata[2]) m_ovr = 0;
                    end
                    4'hE: if (reg_wdata[1:0] != 2'b11) m_sel = reg_wdata[1:0];
                    default: ;
                endcase
            end
            hv = hs;
            if (hv) m_hit = 1;
            if (ov) m_ovr = 1;
        end
    end

    // per-cycle comparison and memory responder
    always @(negedge clk) begin
        cyc++;
        mem_ready <= mem_req && (cyc % 3 != 1);
        if (rst_n && !finished) begin
            check("R5/R6 rsp_ready", rsp_ready, model_ready());
            check("R7 irq", irq, m_hit && m_ien);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic send(input logic [63:0] d);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = d;
        for (int i = 0; i < 50; i++) begin
            if (rsp_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (!m_busy) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(4'h8, 32'h0, "R1 write index");
        rd(4'hA, 32'h0, "R1 limit");
        rd(4'hC, 32'h0, "R1 control");
        rd(4'hD, 32'h0, "R1 status");
        rd(4'hE, 32'h70, "R1 size");

        wr(4'h0, 32'h1234_56FF);
        wr(4'h4, 32'h0000_0001);
        rd(4'h0, 32'h1234_5680, "R10 lower base");
        rd(4'h4, 32'h0000_0001, "R10 upper base");

        wr(4'hE, 32'h1);
        rd(4'hE, 32'h71, "R3 select 16");
        wr(4'hA, 32'd5);
        wr(4'hC, 32'h2);
        rd(4'hC, 32'h2, "R5 control readback");
        for (int i = 0; i < 4; i++) send(64'hA000_0000_0000_0000 + i);
        rd(4'h8, 32'd4, "R2 index after four");
        rd(4'hD, 32'h0, "R6 no flag yet");
        send(64'hA5);
        rd(4'hD, 32'h1, "R6 flag at limit");
        check("R7 irq masked", irq, 0);

        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = 64'hBEEF;
        repeat (4) begin
            @(negedge clk);
            check("R6 stalled", rsp_ready, 0);
        end
        rsp_valid = 1'b0;
        wr(4'hD, 32'h1);
        send(64'hBEEF);
        rd(4'h8, 32'd6, "R6 resumed");

        wr(4'hC, 32'h3);
        wr(4'hA, 32'd2);
        send(64'hC1);
        @(negedge clk);
        check("R7 irq raised", irq, 1);
        wr(4'hD, 32'h1);
        @(negedge clk);
        check("R7 irq cleared", irq, 0);

        wr(4'hA, 32'd0);
        for (int i = 0; i < 8; i++) send(64'hD0 + i);
        rd(4'h8, 32'd15, "R8 index before full");
        send(64'hDEAD);
        rd(4'hD, 32'h4, "R8 overrun flag");
        rd(4'h8, 32'd15, "R8 index unchanged");
        wr(4'hD, 32'h4);
        rd(4'hD, 32'h0, "R8 overrun cleared");
        host_rd_idx = 8'd8;
        send(64'hE0);
        rd(4'h8, 32'd0, "R2 wrap to slot 0");
        send(64'hE1);
        wr(4'h8, 32'h0005);
        rd(4'h8, 32'd1, "R4 plain write ignored");
        wr(4'h8, 32'h8000);
        rd(4'h8, 32'd0, "R4 index reset");

        wr(4'hE, 32'h0);
        host_rd_idx = 8'd0;
        send(64'hF1);
        rd(4'h8, 32'd1, "R3 depth 2 store");
        send(64'hF2);
        rd(4'hD, 32'h4, "R3 depth 2 full");
        rd(4'h8, 32'd1, "R8 depth 2 unchanged");
        wr(4'hD, 32'h4);
        wr(4'hE, 32'h3);
        rd(4'hE, 32'h70, "R3 reserved select ignored");

        wr(4'hE, 32'h2);
        for (int i = 0; i < 3; i++) send(64'h1_0000 + i);
        rd(4'h8, 32'd4, "R3 depth 256 index");

        wr(4'hC, 32'h0);
        rd(4'hC, 32'h0, "R5 disabled readback");
        @(negedge clk);
        rsp_valid = 1'b1;
        @(negedge clk);
        check("R5 no intake when off", rsp_ready, 0);
        rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 all writes seen", exp_addr.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule